// File: doc/BRIEF.md
# Staged Waveform Playback Sequencer

This block walks a waveform playback engine through a table of stages. Each stage is a window of sample memory, described by a base address, a sample count and a repeat count. For every sample-clock enable pulse that falls while playback is active, the block presents one memory read address and raises a one-cycle valid strobe. Downstream logic reads the sample and forwards it to the converter. Every output channel receives the same address and strobe from a single set of sequencer state, so all channels stay in lockstep.

Software fills the stage table through a small write port while the block is idle. It then selects one of four progression modes and the index of the last stage in use, and pulses `start` to arm the block. An external qualifier supplies trigger pulses. The first trigger begins playback. In stepped and burst modes, later triggers move playback from one stage to the next. `stop` returns the block to idle at any time.

Top module: `wave_stage_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `busy` is 0 and every `ch_valid` bit is 0. A `start` pulse while idle sets `busy` on the next cycle. No valid strobe appears until a trigger arrives. A trigger while idle is ignored.
- R2: Mode 0 (once). A trigger starts playback at stage 0 and plays each stage up to `last_idx` once. The final stage then repeats until stop.
- R3: Mode 1 (cycle). A trigger starts playback. After stage `last_idx`, playback wraps to stage 0 and continues without further triggers.
- R4: Mode 2 (step). Each trigger plays exactly one stage, and the stage index wraps to 0 after `last_idx`. A trigger that arrives while a stage is still playing is ignored.
- R5: Mode 2 (step). While waiting for a trigger after a stage completes, each enable outputs the next stage's base address plus offsets 0 to 7, repeated in a cycle. The next trigger plays that stage from offset 0.
- R6: Mode 3 (burst). The current stage buffer repeats with no limit. A trigger is held until the current pass through the buffer ends, and playback then moves to the next stage, wrapping after `last_idx`. The repeat count is not used.
- R7: In modes 0, 1 and 2, a stage is complete after its buffer has played repeat-count times. A repeat count of 0 is treated as 1.
- R8: A cycle with `stop` high leaves `busy` at 0 and all `ch_valid` bits at 0 on the next cycle, even if an enable arrived in the same cycle.
- R9: The table write port takes the field code on `cfg_field`: 0 is the base address, 1 is the sample count, 2 is the repeat count. Writes are accepted only while idle. A sample count below 8 is stored as 8.
- R10: For each enable during playback, `ch_valid` is high for exactly the following cycle. `ch_addr` then carries base plus offset, and offsets rise by one per enable. All channels carry identical values.
- R11: The sample offset advances only on an enable. Cycles without an enable produce no strobe and do not skip an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Stage table write strobe |
| cfg_idx | input | IDX_W | Stage table entry to write |
| cfg_field | input | 2 | Field code (0 base, 1 count, 2 repeats) |
| cfg_data | input | CFG_W | Write data |
| mode | input | 2 | Progression mode, sampled at start |
| last_idx | input | IDX_W | Last stage in use, sampled at start |
| start | input | 1 | Arm pulse |
| trig | input | 1 | Qualified trigger pulse |
| stop | input | 1 | Halt and return to idle |
| smp_en | input | 1 | Sample-clock enable |
| ch_addr | output | CHANNELS*ADDR_W | Read address for each channel |
| ch_valid | output | CHANNELS | Sample-valid strobe for each channel |
| busy | output | 1 | High when not idle |
| cur_stage | output | IDX_W | Stage index currently selected |

## Verification
A corrupted offset or stage index shows up at the ports on the very next enable. The valid strobe one cycle later carries an address that is not the stage base plus the expected offset. The bench follows each mode sample by sample, so a fault is reported at the first strobe it affects. A wrong mode decision, such as advancing early, repeating too often, honouring a trigger during play, or dropping a held burst trigger, changes the address at the next buffer boundary. A state that fails to leave playback on stop shows as a strobe or `busy` one cycle after the stop.

// File: rtl/wss_pkg.sv
package wss_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_ARMED = 2'd1,
      SEQ_PLAY  = 2'd2,
      SEQ_HOLD  = 2'd3
   } seq_state_t;

   typedef enum logic [1:0] {
      MODE_ONCE  = 2'd0,
      MODE_CYCLE = 2'd1,
      MODE_STEP  = 2'd2,
      MODE_BURST = 2'd3
   } play_mode_t;

   localparam logic [1:0] FLD_BASE  = 2'd0;
   localparam logic [1:0] FLD_COUNT = 2'd1;
   localparam logic [1:0] FLD_REPS  = 2'd2;
endpackage

// File: rtl/wss_stage_table.sv
module wss_stage_table
   import wss_pkg::*;
#(
   parameter int STAGES  = 4,
   parameter int IDX_W   = 2,
   parameter int ADDR_W  = 16,
   parameter int LEN_W   = 16,
   parameter int LOOP_W  = 8,
   parameter int CFG_W   = 16,
   parameter int MIN_LEN = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [1:0]        wr_field,
   input  logic [CFG_W-1:0]  wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [ADDR_W-1:0] rd_base,
   output logic [LEN_W-1:0]  rd_count,
   output logic [LOOP_W-1:0] rd_reps
);
   localparam logic [LEN_W-1:0] COUNT_FLOOR = LEN_W'(MIN_LEN);

   logic [ADDR_W-1:0] base_q  [STAGES];
   logic [LEN_W-1:0]  count_q [STAGES];
   logic [LOOP_W-1:0] reps_q  [STAGES];
   logic [LEN_W-1:0]  count_in;

   always_comb begin
      count_in = wr_data[LEN_W-1:0];
      if (count_in < COUNT_FLOOR) count_in = COUNT_FLOOR;
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_entry
      logic hit;
      assign hit = wr_en && (int'(wr_idx) == g);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q[g]  <= '0;
            count_q[g] <= COUNT_FLOOR;
            reps_q[g]  <= LOOP_W'(1);
         end else if (hit) begin
            case (wr_field)
               FLD_BASE:  base_q[g]  <= wr_data[ADDR_W-1:0];
               FLD_COUNT: count_q[g] <= count_in;
               FLD_REPS:  reps_q[g]  <= wr_data[LOOP_W-1:0];
               default:   ;
            endcase
         end
      end
   end

   always_comb begin
      rd_base  = '0;
      rd_count = COUNT_FLOOR;
      rd_reps  = LOOP_W'(1);
      for (int i = 0; i < STAGES; i++) begin
         if (int'(rd_idx) == i) begin
            rd_base  = base_q[i];
            rd_count = count_q[i];
            rd_reps  = reps_q[i];
         end
      end
   end
endmodule

// File: rtl/wss_ctrl.sv
module wss_ctrl
   import wss_pkg::*;
#(
   parameter int STAGES = 4,
   parameter int IDX_W  = 2,
   parameter int ADDR_W = 16,
   parameter int LEN_W  = 16,
   parameter int LOOP_W = 8,
   parameter int HOLD_N = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              trig,
   input  logic              stop,
   input  logic              smp_en,
   input  logic [1:0]        mode_in,
   input  logic [IDX_W-1:0]  last_in,
   input  logic [ADDR_W-1:0] stg_base,
   input  logic [LEN_W-1:0]  stg_count,
   input  logic [LOOP_W-1:0] stg_reps,
   output logic [IDX_W-1:0]  stg_idx,
   output logic              busy,
   output logic              emit,
   output logic [ADDR_W-1:0] emit_addr
);
   localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(STAGES - 1);
   localparam logic [LEN_W-1:0] HOLD_END = LEN_W'(HOLD_N - 1);

   seq_state_t        state_q;
   play_mode_t        mode_q;
   logic [IDX_W-1:0]  last_q, stg_q, stg_nxt, last_clamped;
   logic [LEN_W-1:0]  off_q;
   logic [LOOP_W-1:0] lp_q;
   logic              pend_q;
   logic              buf_end, reps_done;
   logic [LOOP_W:0]   reps_eff, lp_inc;

   assign last_clamped = (last_in > TOP_IDX) ? TOP_IDX : last_in;
   assign stg_nxt      = (stg_q == last_q) ? '0 : stg_q + 1'b1;
   assign buf_end      = (off_q == stg_count - 1'b1);
   assign reps_eff     = (stg_reps == '0) ? (LOOP_W+1)'(1) : {1'b0, stg_reps};
   assign lp_inc       = {1'b0, lp_q} + 1'b1;
   assign reps_done    = (lp_inc >= reps_eff);

   assign emit = !stop && smp_en &&
                 ((state_q == SEQ_PLAY) || ((state_q == SEQ_HOLD) && !trig));
   assign emit_addr = stg_base + ADDR_W'(off_q);
   assign busy      = (state_q != SEQ_IDLE);
   assign stg_idx   = stg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         mode_q  <= MODE_ONCE;
         last_q  <= '0;
         stg_q   <= '0;
         off_q   <= '0;
         lp_q    <= '0;
         pend_q  <= 1'b0;
      end else if (stop) begin
         state_q <= SEQ_IDLE;
         pend_q  <= 1'b0;
      end else begin
         case (state_q)
            SEQ_IDLE: if (start) begin
               state_q <= SEQ_ARMED;
               mode_q  <= play_mode_t'(mode_in);
               last_q  <= last_clamped;
               stg_q   <= '0;
               off_q   <= '0;
               lp_q    <= '0;
               pend_q  <= 1'b0;
            end
            SEQ_ARMED: if (trig) begin
               state_q <= SEQ_PLAY;
               stg_q   <= '0;
               off_q   <= '0;
               lp_q    <= '0;
            end
            SEQ_PLAY: begin
               if ((mode_q == MODE_BURST) && trig) pend_q <= 1'b1;
               if (smp_en) begin
                  if (!buf_end) begin
                     off_q <= off_q + 1'b1;
                  end else begin
                     off_q <= '0;
                     if (mode_q == MODE_BURST) begin
                        if (pend_q || trig) begin
                           stg_q  <= stg_nxt;
                           pend_q <= 1'b0;
                        end
                     end else if (!reps_done) begin
                        lp_q <= lp_q + 1'b1;
                     end else begin
                        lp_q <= '0;
                        case (mode_q)
                           MODE_ONCE:  if (stg_q != last_q) stg_q <= stg_nxt;
                           MODE_CYCLE: stg_q <= stg_nxt;
                           default: begin
                              stg_q   <= stg_nxt;
                              state_q <= SEQ_HOLD;
                           end
                        endcase
                     end
                  end
               end
            end
            default: begin
               if (trig) begin
                  state_q <= SEQ_PLAY;
                  off_q   <= '0;
                  lp_q    <= '0;
               end else if (smp_en) begin
                  off_q <= (off_q >= HOLD_END) ? '0 : off_q + 1'b1;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/wss_chan_out.sv
module wss_chan_out #(
   parameter int CHANNELS = 2,
   parameter int ADDR_W   = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       emit,
   input  logic [ADDR_W-1:0]          emit_addr,
   output logic [CHANNELS*ADDR_W-1:0] ch_addr,
   output logic [CHANNELS-1:0]        ch_valid
);
   for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ch_valid[c]                   <= 1'b0;
            ch_addr[c*ADDR_W +: ADDR_W]   <= '0;
         end else begin
            ch_valid[c] <= emit;
            if (emit) ch_addr[c*ADDR_W +: ADDR_W] <= emit_addr;
         end
      end
   end
endmodule

// File: rtl/wave_stage_seq.sv
module wave_stage_seq
   import wss_pkg::*;
#(
   parameter int STAGES   = 4,
   parameter int IDX_W    = 2,
   parameter int ADDR_W   = 16,
   parameter int LEN_W    = 16,
   parameter int LOOP_W   = 8,
   parameter int CFG_W    = 16,
   parameter int CHANNELS = 2,
   parameter int HOLD_N   = 8,
   parameter int MIN_LEN  = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_we,
   input  logic [IDX_W-1:0]           cfg_idx,
   input  logic [1:0]                 cfg_field,
   input  logic [CFG_W-1:0]           cfg_data,
   input  logic [1:0]                 mode,
   input  logic [IDX_W-1:0]           last_idx,
   input  logic                       start,
   input  logic                       trig,
   input  logic                       stop,
   input  logic                       smp_en,
   output logic [CHANNELS*ADDR_W-1:0] ch_addr,
   output logic [CHANNELS-1:0]        ch_valid,
   output logic                       busy,
   output logic [IDX_W-1:0]           cur_stage
);
   if (STAGES < 1 || STAGES > (1 << IDX_W)) begin : g_bad_stages
      $error("STAGES must fit in IDX_W bits");
   end
   if (CFG_W < ADDR_W || CFG_W < LEN_W || CFG_W < LOOP_W) begin : g_bad_cfg
      $error("CFG_W narrower than a table field");
   end
   if (MIN_LEN < HOLD_N || HOLD_N < 1) begin : g_bad_hold
      $error("MIN_LEN must cover the hold window");
   end
   if (CHANNELS < 1) begin : g_bad_ch
      $error("CHANNELS must be positive");
   end

   logic [ADDR_W-1:0] stg_base, emit_addr;
   logic [LEN_W-1:0]  stg_count;
   logic [LOOP_W-1:0] stg_reps;
   logic              emit;
   logic              cfg_ok;

   assign cfg_ok = cfg_we && !busy;

   wss_stage_table #(
      .STAGES(STAGES), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
      .LOOP_W(LOOP_W), .CFG_W(CFG_W), .MIN_LEN(MIN_LEN)
   ) u_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_ok), .wr_idx(cfg_idx), .wr_field(cfg_field), .wr_data(cfg_data),
      .rd_idx(cur_stage),
      .rd_base(stg_base), .rd_count(stg_count), .rd_reps(stg_reps)
   );

   wss_ctrl #(
      .STAGES(STAGES), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
      .LOOP_W(LOOP_W), .HOLD_N(HOLD_N)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .start(start), .trig(trig), .stop(stop), .smp_en(smp_en),
      .mode_in(mode), .last_in(last_idx),
      .stg_base(stg_base), .stg_count(stg_count), .stg_reps(stg_reps),
      .stg_idx(cur_stage), .busy(busy), .emit(emit), .emit_addr(emit_addr)
   );

   wss_chan_out #(
      .CHANNELS(CHANNELS), .ADDR_W(ADDR_W)
   ) u_out (
      .clk(clk), .rst_n(rst_n),
      .emit(emit), .emit_addr(emit_addr),
      .ch_addr(ch_addr), .ch_valid(ch_valid)
   );
endmodule

// File: rtl/wss_checker.sv
module wss_checker #(
   parameter int CHANNELS = 2,
   parameter int ADDR_W   = 16
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       start,
   input logic                       stop,
   input logic                       smp_en,
   input logic                       busy,
   input logic [CHANNELS*ADDR_W-1:0] ch_addr,
   input logic [CHANNELS-1:0]        ch_valid
);
   AST_STOP_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> (!busy && (ch_valid == '0)));   // R8

   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (ch_valid == '0));   // R1

   AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !stop) |=> busy);   // R1

   AST_VALID_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
      ch_valid[0] |-> $past(smp_en));   // R10

   for (genvar c = 1; c < CHANNELS; c++) begin : g_lock
      AST_CH_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_valid[c] == ch_valid[0]) &&
         (!ch_valid[0] || (ch_addr[c*ADDR_W +: ADDR_W] == ch_addr[ADDR_W-1:0])));   // R10
   end
endmodule

bind wave_stage_seq wss_checker #(.CHANNELS(CHANNELS), .ADDR_W(ADDR_W)) u_wss_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .smp_en(smp_en),
   .busy(busy), .ch_addr(ch_addr), .ch_valid(ch_valid)
);

// File: tb/tb_wave_stage_seq.sv
`timescale 1ns/1ps
module tb_wave_stage_seq;
   localparam int ADDR_W = 16;
   localparam int IDX_W  = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [IDX_W-1:0]  cfg_idx = '0;
   logic [1:0]        cfg_field = '0;
   logic [15:0]       cfg_data = '0;
   logic [1:0]        mode = '0;
   logic [IDX_W-1:0]  last_idx = '0;
   logic              start = 1'b0, trig = 1'b0, stop = 1'b0, smp_en = 1'b0;
   logic [2*ADDR_W-1:0] ch_addr;
   logic [1:0]        ch_valid;
   logic              busy;
   logic [IDX_W-1:0]  cur_stage;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   wave_stage_seq dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_field(cfg_field), .cfg_data(cfg_data), .mode(mode), .last_idx(last_idx),
      .start(start), .trig(trig), .stop(stop), .smp_en(smp_en),
      .ch_addr(ch_addr), .ch_valid(ch_valid), .busy(busy), .cur_stage(cur_stage)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic cfg_write(input int idx, input int fld, input int data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_field = 2'(fld); cfg_data = 16'(data);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic arm(input int m, input int last, input string tag);
      @(negedge clk);
      mode = 2'(m); last_idx = IDX_W'(last); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy === 1'b1, tag, "busy after start", int'(busy), 1);
   endtask

   task automatic pulse_trig();
      @(negedge clk) trig = 1'b1;
      @(negedge clk) trig = 1'b0;
   endtask

   task automatic step_exp(input int exp_a, input string tag);
      @(negedge clk) smp_en = 1'b1;
      @(negedge clk) smp_en = 1'b0;
      check(ch_valid === 2'b11, tag, "valid", int'(ch_valid), 3);
      check(ch_addr[ADDR_W-1:0] === ADDR_W'(exp_a), tag, "addr ch0",
            int'(ch_addr[ADDR_W-1:0]), exp_a);
      check(ch_addr[2*ADDR_W-1:ADDR_W] === ADDR_W'(exp_a), tag, "addr ch1",
            int'(ch_addr[2*ADDR_W-1:ADDR_W]), exp_a);
   endtask

   task automatic step_none(input string tag);
      @(negedge clk) smp_en = 1'b1;
      @(negedge clk) smp_en = 1'b0;
      check(ch_valid === 2'b00, tag, "no strobe", int'(ch_valid), 0);
   endtask

   task automatic play_seg(input int base, input int first, input int cnt,
                           input int reps, input string tag);
      for (int r = 0; r < reps; r++)
         for (int i = 0; i < cnt; i++)
            step_exp(base + first + i, tag);
   endtask

   task automatic halt(input string tag);
      @(negedge clk);
      stop = 1'b1; smp_en = 1'b1;
      @(negedge clk);
      stop = 1'b0; smp_en = 1'b0;
      check(busy === 1'b0, tag, "busy after stop", int'(busy), 0);
      check(ch_valid === 2'b00, tag, "valid after stop", int'(ch_valid), 0);
   endtask

   task automatic t_reset_idle();
      check(busy === 1'b0, "R1", "busy at reset", int'(busy), 0);
      check(ch_valid === 2'b00, "R1", "valid at reset", int'(ch_valid), 0);
      pulse_trig();
      check(busy === 1'b0, "R1", "trigger while idle", int'(busy), 0);
      step_none("R1");
   endtask

   task automatic t_once();
      arm(0, 2, "R1");
      step_none("R1");
      pulse_trig();
      play_seg(100, 0, 8, 2, "R7");
      play_seg(200, 0, 10, 1, "R2");
      play_seg(300, 0, 8, 3, "R2");
      halt("R8");
      step_none("R8");
   endtask

   task automatic t_cycle();
      arm(1, 2, "R3");
      pulse_trig();
      play_seg(100, 0, 8, 2, "R3");
      play_seg(200, 0, 4, 1, "R3");
      repeat (3) begin
         @(negedge clk);
         check(ch_valid === 2'b00, "R11", "idle cycle strobe", int'(ch_valid), 0);
      end
      play_seg(200, 4, 6, 1, "R11");
      play_seg(300, 0, 8, 1, "R3");
      play_seg(100, 0, 8, 2, "R3");
      play_seg(200, 0, 10, 1, "R3");
      halt("R8");
   endtask

   task automatic t_step();
      arm(2, 2, "R4");
      pulse_trig();
      play_seg(100, 0, 4, 1, "R4");
      pulse_trig();
      play_seg(100, 4, 4, 1, "R4");
      play_seg(100, 0, 8, 1, "R7");
      play_seg(200, 0, 8, 2, "R5");
      play_seg(200, 0, 3, 1, "R5");
      pulse_trig();
      play_seg(200, 0, 10, 1, "R4");
      play_seg(300, 0, 8, 1, "R5");
      pulse_trig();
      play_seg(300, 0, 8, 1, "R4");
      play_seg(100, 0, 8, 2, "R5");
      halt("R8");
   endtask

   task automatic t_burst();
      arm(3, 2, "R6");
      pulse_trig();
      play_seg(100, 0, 8, 3, "R6");
      play_seg(100, 0, 3, 1, "R6");
      pulse_trig();
      play_seg(100, 3, 5, 1, "R6");
      play_seg(200, 0, 10, 2, "R6");
      pulse_trig();
      play_seg(200, 0, 10, 1, "R6");
      play_seg(300, 0, 8, 1, "R6");
      play_seg(300, 0, 8, 1, "R6");
      halt("R8");
   endtask

   task automatic t_cfg();
      arm(1, 2, "R9");
      cfg_write(0, 0, 999);
      cfg_write(0, 1, 20);
      pulse_trig();
      play_seg(100, 0, 8, 2, "R9");
      play_seg(200, 0, 2, 1, "R9");
      halt("R8");
      cfg_write(3, 0, 400);
      cfg_write(3, 1, 3);
      cfg_write(3, 2, 0);
      arm(1, 3, "R9");
      pulse_trig();
      play_seg(100, 0, 8, 2, "R9");
      play_seg(200, 0, 10, 1, "R9");
      play_seg(300, 0, 8, 1, "R9");
      play_seg(400, 0, 8, 1, "R9");
      play_seg(100, 0, 8, 1, "R7");
      halt("R8");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_idle();
      cfg_write(0, 0, 100); cfg_write(0, 1, 8);  cfg_write(0, 2, 2);
      cfg_write(1, 0, 200); cfg_write(1, 1, 10); cfg_write(1, 2, 1);
      cfg_write(2, 0, 300); cfg_write(2, 1, 8);  cfg_write(2, 2, 1);
      t_once();
      t_cycle();
      t_step();
      t_burst();
      t_cfg();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule